// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block is the digital core of a processor supervisor. It drives a pair of complementary system reset outputs. There are three causes of reset: a supply-good flag from an external voltage comparator, an active-low push-button request, and a watchdog. The watchdog expects the supervised processor to toggle a kick line regularly. Every reset is stretched by one shared recovery timer, so the reset outputs are released only after a fixed quiet period with no cause present.

All periods are parameters counted in cycles of a free-running clock. Real designs set them to millisecond and second values; a simulation can use a few dozen cycles. The push-button, kick and kick-floating inputs are asynchronous, and each passes through a two-stage synchronizer. The supply flag is taken as already synchronous. A separate power-on input initializes the logic asynchronously with reset asserted.

When the kick line is floating, an external detector raises a flag and the watchdog is serviced internally. A processor that does not use the watchdog is therefore never reset by it.

Top module: `sup_reset_wdog`

## Requirements
- R1: At the first clock edge that samples `supply_ok` low, `rst_out_n` goes low. It stays low for as long as `supply_ok` stays low.
- R2: After the last reset cause clears, `rst_out_n` rises exactly REC_CYCLES clock edges later. For the supply, the count starts with the first edge that samples `supply_ok` high.
- R3: A drop of `supply_ok` while the recovery timer is running restarts the timer. Release then comes REC_CYCLES edges after `supply_ok` returns high.
- R4: A low on `man_rst_n` asserts reset on the third clock edge. Reset holds for the whole time the input is low. Release comes REC_CYCLES+2 edges after the input returns high.
- R5: A rising or a falling change of `kick` clears the watchdog count. A kick pulse only one clock wide is seen as two changes.
- R6: If `kick` does not change, the watchdog expires. Reset is asserted WD_CYCLES+3 edges after the last change of `kick`. `wd_expire` is high for exactly that one cycle.
- R7: A watchdog-caused reset lasts exactly REC_CYCLES edges.
- R8: The watchdog count is held at zero while reset is asserted. With no kicks, the next expiry comes exactly WD_CYCLES edges after the release.
- R9: While `kick_float` is high, the watchdog never expires, even with no kick changes.
- R10: `rst_out` is always the inverse of `rst_out_n`.
- R11: While `por_n` is low, `rst_out_n` is low. After `por_n` rises with no other cause present, release comes REC_CYCLES edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Asynchronous power-on initialization, active low |
| supply_ok | input | 1 | Synchronous supply-good flag from the comparator |
| man_rst_n | input | 1 | Push-button reset request, active low, asynchronous |
| kick | input | 1 | Watchdog service line, asynchronous |
| kick_float | input | 1 | High when the kick line is floating; disables the watchdog |
| rst_out_n | output | 1 | System reset, active low |
| rst_out | output | 1 | System reset, active high |
| wd_expire | output | 1 | One-cycle pulse when the watchdog expires |

## Verification
A recovery counter that is not cleared or mis-loaded shows up at the very next release: `rst_out_n` rises too early or too late by a whole number of cycles. Every release is therefore timed to the exact edge. A watchdog counter that keeps running during reset, or misses one polarity of kick change, moves the next expiry by a number of cycles that can be measured. So the bench times each expiry from the last kick change and from the preceding release. A broken float path shows up within one watchdog period as an unexpected reset.

// File: rtl/sup_reset_wdog.sv
module sup_reset_wdog #(
  parameter int REC_CYCLES  = 20,
  parameter int WD_CYCLES   = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_ok,
  input  logic man_rst_n,
  input  logic kick,
  input  logic kick_float,
  output logic rst_out_n,
  output logic rst_out,
  output logic wd_expire
);
  localparam int RW = $clog2(REC_CYCLES + 1);
  localparam int WW = $clog2(WD_CYCLES + 1);
  localparam logic [RW-1:0] REC_LAST = RW'(REC_CYCLES - 1);
  localparam logic [WW-1:0] WD_LAST  = WW'(WD_CYCLES - 1);

  logic [SYNC_STAGES-1:0] mr_sync, kick_sync, flt_sync;
  logic                   kick_d;
  logic                   asserted;
  logic [RW-1:0]          rec_cnt;
  logic [WW-1:0]          wd_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mr_sync   <= '1;
      kick_sync <= '0;
      flt_sync  <= '1;
      kick_d    <= 1'b0;
    end else begin
      mr_sync   <= {mr_sync[SYNC_STAGES-2:0], man_rst_n};
      kick_sync <= {kick_sync[SYNC_STAGES-2:0], kick};
      flt_sync  <= {flt_sync[SYNC_STAGES-2:0], kick_float};
      kick_d    <= kick_sync[SYNC_STAGES-1];
    end
  end

  wire mr_s      = mr_sync[SYNC_STAGES-1];
  wire float_s   = flt_sync[SYNC_STAGES-1];
  wire kick_edge = kick_sync[SYNC_STAGES-1] ^ kick_d;
  wire hold      = !supply_ok || !mr_s;
  wire wd_clear  = asserted || kick_edge || float_s;
  wire wd_fire   = !wd_clear && (wd_cnt == WD_LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        wd_cnt <= '0;
    else if (wd_clear) wd_cnt <= '0;
    else if (wd_fire)  wd_cnt <= '0;
    else               wd_cnt <= wd_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      asserted <= 1'b1;
      rec_cnt  <= '0;
    end else if (hold || wd_fire) begin
      asserted <= 1'b1;
      rec_cnt  <= '0;
    end else if (asserted) begin
      if (rec_cnt == REC_LAST) begin
        asserted <= 1'b0;
        rec_cnt  <= '0;
      end else begin
        rec_cnt <= rec_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) wd_expire <= 1'b0;
    else        wd_expire <= wd_fire;
  end

  assign rst_out_n = !asserted;
  assign rst_out   = asserted;
endmodule

module sup_reset_wdog_chk (
  input logic clk,
  input logic por_n,
  input logic supply_ok,
  input logic rst_out_n,
  input logic rst_out,
  input logic wd_expire,
  input logic wd_zero
);
  assert_supply_low_R1: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok |=> !rst_out_n);
  assert_release_ok_R2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_out_n) |-> $past(supply_ok));
  assert_expire_resets_R6: assert property (@(posedge clk) disable iff (!por_n)
    wd_expire |-> !rst_out_n);
  assert_expire_pulse_R6: assert property (@(posedge clk) disable iff (!por_n)
    wd_expire |=> !wd_expire);
  assert_wd_held_R8: assert property (@(posedge clk) disable iff (!por_n)
    !rst_out_n |=> wd_zero);
  assert_complement_R10: assert property (@(posedge clk) disable iff (!por_n)
    rst_out == !rst_out_n);
endmodule

bind sup_reset_wdog sup_reset_wdog_chk u_chk (
  .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .rst_out_n(rst_out_n),
  .rst_out(rst_out), .wd_expire(wd_expire), .wd_zero(wd_cnt == '0)
);

// File: tb/sup_reset_wdog_tb.sv
module sup_reset_wdog_tb;
  localparam int REC = 20;
  localparam int WD  = 50;

  logic clk = 1'b0;
  logic por_n = 1'b0, supply_ok = 1'b1, man_rst_n = 1'b1, kick = 1'b0, kick_float = 1'b1;
  logic rst_out_n, rst_out, wd_expire;
  int checks = 0, fails = 0, cyc = 0, low_cnt = 0, exp_cnt = 0, compl_bad = 0;
  bit done = 1'b0;

  always #5ns clk = ~clk;

  sup_reset_wdog #(.REC_CYCLES(REC), .WD_CYCLES(WD), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .man_rst_n(man_rst_n),
    .kick(kick), .kick_float(kick_float), .rst_out_n(rst_out_n),
    .rst_out(rst_out), .wd_expire(wd_expire));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (por_n) begin
      if (!rst_out_n) low_cnt++;
      if (wd_expire) exp_cnt++;
      if (rst_out !== !rst_out_n) compl_bad++;
    end
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", cyc, 100000);
      summary();
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  function automatic int rnd(input int lo, input int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  task automatic edges_until(input logic want, output int n);
    n = 0;
    while (rst_out_n !== want && n < 5000) begin @(posedge clk); @(negedge clk); n++; end
  endtask

  initial begin
    int n, lc, ec;
    void'($urandom(32'd2718));
    @(negedge clk); tick(3);
    chk(rst_out_n === 1'b0 && rst_out === 1'b1, "R11 por hold", rst_out_n, 0);
    por_n = 1'b1;
    edges_until(1'b1, n);
    chk(n == REC, "R11 first release", n, REC);

    supply_ok = 1'b0; tick(1);
    chk(rst_out_n === 1'b0, "R1 supply drop", rst_out_n, 0);
    tick(rnd(5, 30));
    chk(rst_out_n === 1'b0, "R1 held low", rst_out_n, 0);
    supply_ok = 1'b1;
    edges_until(1'b1, n);
    chk(n == REC, "R2 supply release", n, REC);

    for (int k = 0; k < 6; k++) begin
      tick(rnd(3, 20));
      supply_ok = 1'b0; tick(1); supply_ok = 1'b1;
      tick(rnd(1, REC - 2));
      chk(rst_out_n === 1'b0, "R3 timer running", rst_out_n, 0);
      supply_ok = 1'b0; tick(rnd(1, 4)); supply_ok = 1'b1;
      edges_until(1'b1, n);
      chk(n == REC, "R3 restart after dip", n, REC);
    end

    for (int k = 0; k < 4; k++) begin
      tick(rnd(2, 10));
      man_rst_n = 1'b0; tick(2);
      chk(rst_out_n === 1'b1, "R4 sync delay", rst_out_n, 1);
      tick(1);
      chk(rst_out_n === 1'b0, "R4 asserted", rst_out_n, 0);
      tick(rnd(REC + 5, 3 * REC));
      chk(rst_out_n === 1'b0, "R4 held while low", rst_out_n, 0);
      man_rst_n = 1'b1;
      edges_until(1'b1, n);
      chk(n == REC + 2, "R4 release", n, REC + 2);
    end

    kick_float = 1'b0;
    lc = low_cnt; ec = exp_cnt;
    for (int k = 0; k < 12; k++) begin
      tick(rnd(1, WD - 10));
      kick = ~kick;
    end
    tick(rnd(1, WD - 10));
    kick = 1'b1; tick(1); kick = 1'b0;
    tick(WD - 5);
    kick = 1'b1; tick(1); kick = 1'b0;
    chk(low_cnt == lc && exp_cnt == ec, "R5 kicks keep alive", low_cnt - lc, 0);
    edges_until(1'b0, n);
    chk(n == WD + 3, "R5 R6 expiry from last change", n, WD + 3);
    chk(wd_expire === 1'b1, "R6 expire pulse", wd_expire, 1);
    tick(1);
    chk(wd_expire === 1'b0, "R6 pulse one cycle", wd_expire, 0);
    edges_until(1'b1, n);
    chk(n + 1 == REC, "R7 watchdog reset length", n + 1, REC);
    edges_until(1'b0, n);
    chk(n == WD, "R8 count held during reset", n, WD);
    edges_until(1'b1, n);
    kick_float = 1'b1;
    lc = low_cnt; ec = exp_cnt;
    tick(3 * WD);
    chk(low_cnt == lc && exp_cnt == ec, "R9 floating kick", exp_cnt - ec, 0);
    chk(compl_bad == 0, "R10 complement", compl_bad, 0);
    summary();
  end
endmodule